// File: doc/BRIEF.md
# Large-Send Segmentation Header Sequencer

This block turns one oversized transmit message into a train of wire-sized packets and produces, for each packet, the header field values that a downstream header writer needs. A message descriptor is offered on a valid/ready input. It carries the protocol (TCP or UDP), the payload length in bytes, the buffer address where the header template starts, the initial sequence number and the payload capacity of one packet (the segment size, normally 1460 for TCP and 1472 for UDP, so that every full packet is 1500 bytes on the IP layer).

Each packet record leaves on a valid/ready output. The record holds a segment class (first, continuation, last or single), the IP total length, the TCP sequence and acknowledgment values, the IP fragment offset and more-fragments flag, and four buffer pointers: header start and end, and payload start and end. The header template stays in place at the descriptor address. Between packets the sequencer changes only the fields that move: the remaining length, the sequence value, the sent-byte count and the payload pointer. The payload window slides along the buffer. Checksums, data movement and framing are left to other blocks.

Top module: `lso_seg_seq`

## Requirements
- R1: While reset is held and until a descriptor is accepted, `pkt_valid` is 0 and `desc_ready` is 1.
- R2: A message whose length is at most the segment size, including a zero-length message, yields exactly one packet of class SINGLE. A longer message yields ceil(length / segment size) packets: one FIRST, then CONT packets while the remaining length still exceeds the segment size, then one LAST. Class codes on `pkt_class`: FIRST=0, CONT=1, LAST=2, SINGLE=3.
- R3: `pkt_ip_len` is the packet's payload bytes plus a fixed overhead of 40 for TCP or 28 for UDP. FIRST and CONT packets carry exactly the segment size. LAST and SINGLE packets carry whatever length remains.
- R4: For TCP, the first packet's `pkt_seq` is the descriptor's sequence value, and `pkt_ack` is `pkt_seq` plus the packet's payload bytes (modulo 2^32). Each later packet's `pkt_seq` equals the previous packet's `pkt_ack`. For UDP both fields are 0.
- R5: For UDP, `pkt_frag_off` is the number of payload bytes sent in earlier packets of the message divided by 8. `pkt_more_frag` is 1 on FIRST and CONT packets and 0 on LAST and SINGLE packets. For TCP both fields are 0.
- R6: `pkt_hdr_start` is the descriptor address for every packet of a message. `pkt_hdr_end` is that address plus 40 (TCP) or 8 (UDP). The first packet's `pkt_pay_start` equals `pkt_hdr_end`. `pkt_pay_end` is `pkt_pay_start` plus the packet's payload bytes. Each later `pkt_pay_start` equals the previous `pkt_pay_end`.
- R7: While `pkt_valid` is 1 and `pkt_ready` is 0, `pkt_valid` stays 1 and every record field holds its value.
- R8: `desc_ready` is 0 from the cycle after a descriptor is accepted until the cycle after the last packet of that message is taken. Descriptors offered in that window are ignored and produce no packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken |
| desc_udp | input | 1 | Protocol: 0 = TCP, 1 = UDP |
| desc_len | input | LEN_W | Message payload length in bytes |
| desc_base | input | ADDR_W | Buffer address of the header template |
| desc_seq | input | SEQ_W | Initial TCP sequence value |
| desc_seg | input | LEN_W | Payload bytes per full packet (non-zero) |
| pkt_valid | output | 1 | Packet record offered |
| pkt_ready | input | 1 | Packet record taken |
| pkt_class | output | 2 | Segment class code |
| pkt_ip_len | output | LEN_W | IP total length |
| pkt_seq | output | SEQ_W | TCP sequence value |
| pkt_ack | output | SEQ_W | TCP acknowledgment value |
| pkt_frag_off | output | LEN_W-3 | Fragment offset in 8-byte units |
| pkt_more_frag | output | 1 | More-fragments flag |
| pkt_hdr_start | output | ADDR_W | Header start pointer |
| pkt_hdr_end | output | ADDR_W | Header end pointer |
| pkt_pay_start | output | ADDR_W | Payload start pointer |
| pkt_pay_end | output | ADDR_W | Payload end pointer |

## Verification
The first record of a message appears on the clock edge that follows the descriptor handshake, because it comes from registers loaded by that edge. Each later record appears on the edge after the previous record's handshake, and `desc_ready` returns on the edge after the final handshake. The bench drives inputs and samples outputs on falling edges, so every record is read half a cycle after the edge that produced it. Records are compared against a queue that the driver fills from the requirements, and a comparison happens only when `pkt_valid` is 1. A record that is stalled by `pkt_ready` must still be present at the next falling edge.

// File: rtl/lso_pkg.sv
package lso_pkg;

  typedef enum logic [1:0] {
    SEG_FIRST  = 2'd0,
    SEG_CONT   = 2'd1,
    SEG_LAST   = 2'd2,
    SEG_SINGLE = 2'd3
  } seg_class_e;

endpackage

// File: rtl/lso_rst_sync.sv
module lso_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/lso_class_dec.sv
module lso_class_dec
  import lso_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             first_pkt,
  input  logic [LEN_W-1:0] remain,
  input  logic [LEN_W-1:0] seg_size,
  output seg_class_e       cls,
  output logic [LEN_W-1:0] pay_len,
  output logic             more
);

  always_comb begin
    more    = (remain > seg_size);
    pay_len = more ? seg_size : remain;
    if (first_pkt) cls = more ? SEG_FIRST : SEG_SINGLE;
    else           cls = more ? SEG_CONT  : SEG_LAST;
  end

endmodule

// File: rtl/lso_field_gen.sv
module lso_field_gen
  import lso_pkg::*;
#(
  parameter int unsigned LEN_W        = 16,
  parameter int unsigned SEQ_W        = 32,
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned TCP_HDR_SPAN = 40,
  parameter int unsigned UDP_HDR_SPAN = 8,
  parameter int unsigned TCP_OVH      = 40,
  parameter int unsigned UDP_OVH      = 28,
  localparam int unsigned OFF_W       = LEN_W - 3
) (
  input  logic              udp,
  input  seg_class_e        cls,
  input  logic [LEN_W-1:0]  pay_len,
  input  logic [SEQ_W-1:0]  seq_cur,
  input  logic [LEN_W-1:0]  sent,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] pay_ptr,
  output logic [LEN_W-1:0]  ip_len,
  output logic [SEQ_W-1:0]  seq,
  output logic [SEQ_W-1:0]  ack,
  output logic [OFF_W-1:0]  frag_off,
  output logic              more_frag,
  output logic [ADDR_W-1:0] hdr_start,
  output logic [ADDR_W-1:0] hdr_end,
  output logic [ADDR_W-1:0] pay_start,
  output logic [ADDR_W-1:0] pay_end
);

  logic [LEN_W-1:0]  ovh;
  logic [ADDR_W-1:0] span;

  always_comb begin
    ovh       = udp ? LEN_W'(UDP_OVH) : LEN_W'(TCP_OVH);
    span      = udp ? ADDR_W'(UDP_HDR_SPAN) : ADDR_W'(TCP_HDR_SPAN);
    ip_len    = pay_len + ovh;
    seq       = udp ? '0 : seq_cur;
    ack       = udp ? '0 : seq_cur + SEQ_W'(pay_len);
    frag_off  = udp ? sent[LEN_W-1:3] : '0;
    more_frag = udp && ((cls == SEG_FIRST) || (cls == SEG_CONT));
    hdr_start = base;
    hdr_end   = base + span;
    pay_start = pay_ptr;
    pay_end   = pay_ptr + ADDR_W'(pay_len);
  end

endmodule

// File: rtl/lso_seg_seq.sv
module lso_seg_seq
  import lso_pkg::*;
#(
  parameter int unsigned LEN_W        = 16,
  parameter int unsigned SEQ_W        = 32,
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned TCP_HDR_SPAN = 40,
  parameter int unsigned UDP_HDR_SPAN = 8,
  parameter int unsigned TCP_OVH      = 40,
  parameter int unsigned UDP_OVH      = 28,
  localparam int unsigned OFF_W       = LEN_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic              desc_udp,
  input  logic [LEN_W-1:0]  desc_len,
  input  logic [ADDR_W-1:0] desc_base,
  input  logic [SEQ_W-1:0]  desc_seq,
  input  logic [LEN_W-1:0]  desc_seg,
  output logic              pkt_valid,
  input  logic              pkt_ready,
  output logic [1:0]        pkt_class,
  output logic [LEN_W-1:0]  pkt_ip_len,
  output logic [SEQ_W-1:0]  pkt_seq,
  output logic [SEQ_W-1:0]  pkt_ack,
  output logic [OFF_W-1:0]  pkt_frag_off,
  output logic              pkt_more_frag,
  output logic [ADDR_W-1:0] pkt_hdr_start,
  output logic [ADDR_W-1:0] pkt_hdr_end,
  output logic [ADDR_W-1:0] pkt_pay_start,
  output logic [ADDR_W-1:0] pkt_pay_end
);

  logic rst_s_n;

  // control state
  logic busy_q, busy_d, first_q, first_d;
  // message state, updated per packet only where the field moves
  logic              udp_q, udp_d;
  logic [LEN_W-1:0]  seg_q, seg_d, rem_q, rem_d, sent_q, sent_d;
  logic [SEQ_W-1:0]  seq_q, seq_d;
  logic [ADDR_W-1:0] base_q, base_d, ptr_q, ptr_d;

  logic              load_en, adv_en, more;
  logic [LEN_W-1:0]  pay_len;
  seg_class_e        cls;

  lso_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  lso_class_dec #(.LEN_W(LEN_W)) u_cls (
    .first_pkt (first_q),
    .remain    (rem_q),
    .seg_size  (seg_q),
    .cls       (cls),
    .pay_len   (pay_len),
    .more      (more)
  );

  lso_field_gen #(
    .LEN_W(LEN_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
    .TCP_HDR_SPAN(TCP_HDR_SPAN), .UDP_HDR_SPAN(UDP_HDR_SPAN),
    .TCP_OVH(TCP_OVH), .UDP_OVH(UDP_OVH)
  ) u_fld (
    .udp       (udp_q),
    .cls       (cls),
    .pay_len   (pay_len),
    .seq_cur   (seq_q),
    .sent      (sent_q),
    .base      (base_q),
    .pay_ptr   (ptr_q),
    .ip_len    (pkt_ip_len),
    .seq       (pkt_seq),
    .ack       (pkt_ack),
    .frag_off  (pkt_frag_off),
    .more_frag (pkt_more_frag),
    .hdr_start (pkt_hdr_start),
    .hdr_end   (pkt_hdr_end),
    .pay_start (pkt_pay_start),
    .pay_end   (pkt_pay_end)
  );

  assign desc_ready = !busy_q;
  assign pkt_valid  = busy_q;
  assign pkt_class  = cls;
  assign load_en    = desc_valid && !busy_q;
  assign adv_en     = busy_q && pkt_ready;

  // next-state
  always_comb begin
    busy_d  = busy_q;
    first_d = first_q;
    udp_d   = udp_q;
    seg_d   = seg_q;
    rem_d   = rem_q;
    sent_d  = sent_q;
    seq_d   = seq_q;
    base_d  = base_q;
    ptr_d   = ptr_q;
    if (load_en) begin
      busy_d  = 1'b1;
      first_d = 1'b1;
      udp_d   = desc_udp;
      seg_d   = desc_seg;
      rem_d   = desc_len;
      sent_d  = '0;
      seq_d   = desc_seq;
      base_d  = desc_base;
      ptr_d   = desc_base + (desc_udp ? ADDR_W'(UDP_HDR_SPAN) : ADDR_W'(TCP_HDR_SPAN));
    end else if (adv_en) begin
      if (more) begin
        first_d = 1'b0;
        rem_d   = rem_q - seg_q;
        sent_d  = sent_q + seg_q;
        seq_d   = seq_q + SEQ_W'(seg_q);
        ptr_d   = ptr_q + ADDR_W'(seg_q);
      end else begin
        busy_d  = 1'b0;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      busy_q  <= 1'b0;
      first_q <= 1'b0;
    end else if (load_en || adv_en) begin
      busy_q  <= busy_d;
      first_q <= first_d;
    end
  end

  // datapath registers, no reset, explicit enable
  always_ff @(posedge clk) begin
    if (load_en || adv_en) begin
      udp_q  <= udp_d;
      seg_q  <= seg_d;
      rem_q  <= rem_d;
      sent_q <= sent_d;
      seq_q  <= seq_d;
      base_q <= base_d;
      ptr_q  <= ptr_d;
    end
  end

endmodule

// File: rtl/lso_seg_seq_chk.sv
module lso_seg_seq_chk #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned SEQ_W  = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TCP_OVH = 40,
  parameter int unsigned UDP_OVH = 28,
  localparam int unsigned OFF_W = LEN_W - 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              desc_ready,
  input logic              pkt_valid,
  input logic              pkt_ready,
  input logic [1:0]        pkt_class,
  input logic [LEN_W-1:0]  pkt_ip_len,
  input logic [SEQ_W-1:0]  pkt_seq,
  input logic [SEQ_W-1:0]  pkt_ack,
  input logic [OFF_W-1:0]  pkt_frag_off,
  input logic              pkt_more_frag,
  input logic [ADDR_W-1:0] pkt_hdr_start,
  input logic [ADDR_W-1:0] pkt_pay_start,
  input logic [ADDR_W-1:0] pkt_pay_end
);

  logic hs, mid;
  logic [LEN_W-1:0] ovh_seen;
  assign hs       = pkt_valid && pkt_ready;
  assign mid      = (pkt_class == 2'd0) || (pkt_class == 2'd1);
  assign ovh_seen = pkt_ip_len - LEN_W'(pkt_pay_end - pkt_pay_start);

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hs && mid |=> pkt_valid && (pkt_class == 2'd1 || pkt_class == 2'd2));

  p_ovh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (ovh_seen == LEN_W'(TCP_OVH) || ovh_seen == LEN_W'(UDP_OVH)));

  p_seq_chain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hs && mid |=> pkt_seq == $past(pkt_ack));

  p_mf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !mid |-> !pkt_more_frag);

  p_ptr_chain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs && mid |=> pkt_pay_start == $past(pkt_pay_end) && $stable(pkt_hdr_start));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_class) && $stable(pkt_ip_len)
      && $stable(pkt_seq) && $stable(pkt_ack) && $stable(pkt_frag_off)
      && $stable(pkt_pay_start) && $stable(pkt_pay_end));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !desc_ready);

endmodule

bind lso_seg_seq lso_seg_seq_chk #(
  .LEN_W(LEN_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .TCP_OVH(TCP_OVH), .UDP_OVH(UDP_OVH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_ready(desc_ready), .pkt_valid(pkt_valid),
  .pkt_ready(pkt_ready), .pkt_class(pkt_class), .pkt_ip_len(pkt_ip_len),
  .pkt_seq(pkt_seq), .pkt_ack(pkt_ack), .pkt_frag_off(pkt_frag_off),
  .pkt_more_frag(pkt_more_frag), .pkt_hdr_start(pkt_hdr_start),
  .pkt_pay_start(pkt_pay_start), .pkt_pay_end(pkt_pay_end)
);

// File: tb/sim_lso_seg_seq.sv
module sim_lso_seg_seq;

  logic clk = 1'b0;
  logic rst_n;
  logic desc_valid, desc_ready, desc_udp;
  logic [15:0] desc_len, desc_seg;
  logic [31:0] desc_base, desc_seq;
  logic pkt_valid, pkt_ready;
  logic [1:0] pkt_class;
  logic [15:0] pkt_ip_len;
  logic [31:0] pkt_seq, pkt_ack;
  logic [12:0] pkt_frag_off;
  logic pkt_more_frag;
  logic [31:0] pkt_hdr_start, pkt_hdr_end, pkt_pay_start, pkt_pay_end;

  always #10 clk = ~clk;

  lso_seg_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_udp(desc_udp),
    .desc_len(desc_len), .desc_base(desc_base), .desc_seq(desc_seq), .desc_seg(desc_seg),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_class(pkt_class),
    .pkt_ip_len(pkt_ip_len), .pkt_seq(pkt_seq), .pkt_ack(pkt_ack),
    .pkt_frag_off(pkt_frag_off), .pkt_more_frag(pkt_more_frag),
    .pkt_hdr_start(pkt_hdr_start), .pkt_hdr_end(pkt_hdr_end),
    .pkt_pay_start(pkt_pay_start), .pkt_pay_end(pkt_pay_end)
  );

  typedef struct {
    logic [1:0]  cls;
    logic [15:0] iplen;
    logic [31:0] seq, ack;
    logic [12:0] off;
    logic        mf;
    logic [31:0] hs, he, ps, pe;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  int ready_mode = 0;       // 0 always, 1 pseudo-random, 2 stalled
  logic [15:0] lfsr = 16'hACE1;
  logic prev_stall = 1'b0;
  logic mon_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected packet list built from the requirements
  task automatic send_msg(input bit udp, input int len, input logic [31:0] base,
                          input logic [31:0] seq0, input int seg);
    int rem = len, sent = 0;
    bit first = 1'b1, big;
    logic [31:0] seq = seq0;
    logic [31:0] span = udp ? 32'd8 : 32'd40;
    logic [31:0] ptr = base + span;
    exp_t e;
    forever begin
      int pl;
      big = (rem > seg);
      pl  = big ? seg : rem;
      e.cls   = first ? (big ? 2'd0 : 2'd3) : (big ? 2'd1 : 2'd2);
      e.iplen = 16'(pl + (udp ? 28 : 40));
      e.seq   = udp ? 32'd0 : seq;
      e.ack   = udp ? 32'd0 : seq + 32'(pl);
      e.off   = udp ? 13'(sent / 8) : 13'd0;
      e.mf    = udp && big;
      e.hs = base; e.he = base + span; e.ps = ptr; e.pe = ptr + 32'(pl);
      exp_q.push_back(e);
      if (!big) break;
      rem -= seg; sent += seg; seq += 32'(seg); ptr += 32'(seg); first = 1'b0;
    end
    @(negedge clk);
    desc_valid = 1'b1; desc_udp = udp; desc_len = 16'(len);
    desc_base = base; desc_seq = seq0; desc_seg = 16'(seg);
    while (!desc_ready) @(negedge clk);
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_q.size() != 0 || pkt_valid) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    chk(exp_q.size() == 0, "R2 all expected packets emitted", 64'(exp_q.size()), 64'd0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pkt_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
      if (prev_stall) chk(pkt_valid === 1'b1, "R7 valid held under stall", 64'(pkt_valid), 64'd1);
      if (pkt_valid && pkt_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8/R2 unexpected packet", 64'(pkt_class), 64'hFF);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(pkt_class == e.cls, "R2 class", 64'(pkt_class), 64'(e.cls));
          chk(pkt_ip_len == e.iplen, "R3 ip length", 64'(pkt_ip_len), 64'(e.iplen));
          chk(pkt_seq == e.seq, "R4 seq", 64'(pkt_seq), 64'(e.seq));
          chk(pkt_ack == e.ack, "R4 ack", 64'(pkt_ack), 64'(e.ack));
          chk(pkt_frag_off == e.off, "R5 frag offset", 64'(pkt_frag_off), 64'(e.off));
          chk(pkt_more_frag == e.mf, "R5 more-frag", 64'(pkt_more_frag), 64'(e.mf));
          chk(pkt_hdr_start == e.hs, "R6 hdr start", 64'(pkt_hdr_start), 64'(e.hs));
          chk(pkt_hdr_end == e.he, "R6 hdr end", 64'(pkt_hdr_end), 64'(e.he));
          chk(pkt_pay_start == e.ps, "R6 pay start", 64'(pkt_pay_start), 64'(e.ps));
          chk(pkt_pay_end == e.pe, "R6 pay end", 64'(pkt_pay_end), 64'(e.pe));
        end
      end
      prev_stall = pkt_valid && !pkt_ready;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; desc_valid = 1'b0; desc_udp = 1'b0; desc_len = '0;
    desc_base = '0; desc_seq = '0; desc_seg = 16'd1460; pkt_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(pkt_valid == 1'b0, "R1 valid low in reset", 64'(pkt_valid), 64'd0);
    chk(desc_ready == 1'b1, "R1 ready high in reset", 64'(desc_ready), 64'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(pkt_valid == 1'b0, "R1 valid low after reset", 64'(pkt_valid), 64'd0);
    chk(desc_ready == 1'b1, "R1 ready high after reset", 64'(desc_ready), 64'd1);
    mon_on = 1'b1;

    // R2 R3 R4 R6: TCP three-packet message
    send_msg(1'b0, 4000, 32'h0000_1000, 32'd0, 1460); drain();
    // R2 boundary: length equal to segment size is single
    send_msg(1'b0, 1460, 32'h0000_2000, 32'd77, 1460); drain();
    // R2 boundary: one byte over gives first + last
    send_msg(1'b0, 1461, 32'h0000_3000, 32'd5, 1460); drain();
    // R2 R3: zero-length signalling message
    send_msg(1'b0, 0, 32'h0000_4000, 32'h1234_5678, 1460); drain();
    // R5: UDP fragmentation
    send_msg(1'b1, 5000, 32'h0001_0000, 32'd9, 1472); drain();
    send_msg(1'b1, 100, 32'h0002_0000, 32'd0, 1472); drain();
    // R7: backpressure, largest message, sequence wrap
    ready_mode = 1;
    send_msg(1'b0, 65535, 32'h0010_0000, 32'hFFFF_F000, 1460); drain();
    send_msg(1'b1, 65535, 32'h0020_0000, 32'd0, 1472); drain();
    // back-to-back messages
    ready_mode = 0;
    send_msg(1'b0, 3000, 32'h0000_5000, 32'd100, 1000);
    send_msg(1'b1, 2944, 32'h0000_6000, 32'd0, 1472); drain();

    // R8: descriptors offered while busy are ignored
    ready_mode = 2;
    send_msg(1'b0, 3000, 32'h0000_7000, 32'd1, 1000);
    for (int i = 0; i < 4; i++) begin
      desc_valid = 1'b1; desc_len = 16'd50; desc_seq = 32'hDEAD_0000; desc_base = 32'h0BAD_0000;
      @(negedge clk);
      chk(desc_ready == 1'b0, "R8 ready low while busy", 64'(desc_ready), 64'd0);
    end
    desc_valid = 1'b0;
    ready_mode = 0;
    drain();
    repeat (3) @(negedge clk);
    chk(pkt_valid == 1'b0, "R8 no packet from ignored descriptor", 64'(pkt_valid), 64'd0);
    chk(desc_ready == 1'b1, "R8 ready back after last packet", 64'(desc_ready), 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule